// File: doc/BRIEF.md
# Three-Source Divided Clock Selector Channel

This block produces one output clock from one of three source clocks. Each source passes through its own programmable integer divider. A glitch-free switch then picks the divided clock of the chosen source. A 2-bit select field names the source. Its top code is reserved to mean "output off", and a separate gate-off strobe is the only way to reach it.

Software programs the block through a small register port that runs on the system clock. The select field of this channel sits in a 32-bit select word that it may share with sibling channels. The field lies at bit `SEL_START + 2*CHAN_IDX`. When that position passes bit 31, the field moves into a second select word and the count starts again from bit 0. The divider field for each source is at that source's divider base address plus four times the channel index.

After every source change or enable, software polls a per-source running flag. The flag is set only once the output is really toggling from that source.

Top module: `divmux_channel`

## Requirements
- R1: After a synchronous reset the select field reads 3 (off), all three divider fields read 0, `running` is 0 and `clk_out` stays low.
- R2: With the default parameters the select field is at bits [3:2] of the word at 0x044. A read of the word at 0x040 returns 0, and a write to it has no effect on the channel. A read of the word at 0x044 returns 0 in every bit outside the field.
- R3: A write to the select word whose field holds 0, 1 or 2 loads that code into the field. A write whose field holds 3 leaves the field, `clk_out` and `running` unchanged.
- R4: A `gate_off` pulse sets the field to 3. It wins over a select write in the same cycle, and `running` is 0 right after that clock edge.
- R5: The divider field for source s is bits [4:0] of the word at `DIV_BASE_s + 4*CHAN_IDX`, which is 0x10C, 0x18C or 0x20C by default. It reads back the value last written, and the other bits of that word read 0.
- R6: While source s is selected with divider value N, `clk_out` has a period of (N+1) source-s periods. N = 0 passes the source through undivided.
- R7: On every select change and every gate-off, no high or low pulse on `clk_out` is shorter than half a period of the fastest source.
- R8: At most one `running` bit is set. Bit s is set only while the field holds s, and it rises within a bounded time after source s is selected.
- R9: After gate-off and the release of the old source, `clk_out` holds low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the register port and status |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| gate_off | input | 1 | One-cycle request to switch the output off |
| rd_addr | input | ADDR_W | Byte address to read |
| rd_data | output | 32 | Read data, one cycle after `rd_addr` |
| src_clk | input | 3 | The three source clocks |
| clk_out | output | 1 | Selected and divided output clock |
| running | output | 3 | Per-source "output is running from this source" flags |

## Verification
The bench sweeps every source against a set of divider values, including pass-through, divide-by-two, an odd ratio and the largest ratio. For each pair it measures the output period against the value computed from that source's period. A divider that is off by one, or that loses the bypass at N = 0, shows up here as a wrong period.

The bench also switches between sources while the output runs and records the narrowest high and low pulse seen over the whole run. A switch that enables the new clock before the old one is released would leave a runt pulse below the fastest source's half period.

Reserved-code writes, writes to the sibling select word, and a gate-off that lands in the same cycle as a select write are all checked through readback and the running flags. A design that accepts code 3 as a source choice, or lets the write win that cycle, would read back the wrong field.

// File: rtl/divmux_pkg.sv
package divmux_pkg;
  localparam int NSRC  = 3;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_OFF = 2'd3;
endpackage

// File: rtl/divmux_regs.sv
module divmux_regs import divmux_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DIV_W = 5,
  parameter int CHAN_IDX = 3,
  parameter int SEL_START = 28,
  parameter logic [ADDR_W-1:0] SEL_ADDR_A = 12'h040,
  parameter logic [ADDR_W-1:0] SEL_ADDR_B = 12'h044,
  parameter logic [ADDR_W-1:0] DIV_BASE0 = 12'h100,
  parameter logic [ADDR_W-1:0] DIV_BASE1 = 12'h180,
  parameter logic [ADDR_W-1:0] DIV_BASE2 = 12'h200
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic                        gate_off,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [31:0]                 rd_data,
  output sel_t                        sel_q,
  output sel_t                        sel_d,
  output logic [NSRC-1:0][DIV_W-1:0]  div_q
);
  localparam int SEL_POS = SEL_START + 2 * CHAN_IDX;
  localparam bit SEL_HI = (SEL_POS >= 32);
  localparam int SEL_SHIFT = SEL_HI ? SEL_POS - 32 : SEL_POS;
  localparam logic [ADDR_W-1:0] SEL_ADDR = SEL_HI ? SEL_ADDR_B : SEL_ADDR_A;

  function automatic logic [ADDR_W-1:0] div_addr(input int s);
    logic [ADDR_W-1:0] base;
    case (s)
      0:       base = DIV_BASE0;
      1:       base = DIV_BASE1;
      default: base = DIV_BASE2;
    endcase
    return base + ADDR_W'(4 * CHAN_IDX);
  endfunction

  sel_t wr_code;
  logic sel_hit;
  logic [31:0] rd_nxt;
  logic unused_wr;

  assign wr_code = wr_data[SEL_SHIFT +: SEL_W];
  assign sel_hit = wr_en && (wr_addr == SEL_ADDR);
  assign unused_wr = ^wr_data;

  // gate-off has priority; the reserved code is refused on the write path
  always_comb begin
    sel_d = sel_q;
    if (gate_off)
      sel_d = SEL_OFF;
    else if (sel_hit && (wr_code != SEL_OFF))
      sel_d = wr_code;
  end

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == SEL_ADDR)
      rd_nxt[SEL_SHIFT +: SEL_W] = sel_q;
    for (int s = 0; s < NSRC; s++)
      if (rd_addr == div_addr(s))
        rd_nxt[DIV_W-1:0] = div_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= SEL_OFF;
      div_q   <= '0;
      rd_data <= '0;
    end else begin
      sel_q   <= sel_d;
      rd_data <= rd_nxt;
      for (int s = 0; s < NSRC; s++)
        if (wr_en && (wr_addr == div_addr(s)))
          div_q[s] <= wr_data[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/divmux_divider.sv
module divmux_divider #(
  parameter int DIV_W = 5
) (
  input  logic             src_clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             dclk,
  output logic             drst
);
  logic [1:0]       rs_q;
  logic [DIV_W-1:0] dv1, dv2, cnt, cnt_nxt, half;
  logic [DIV_W:0]   span;
  logic             q;

  // high phase covers the first (N+1)/2 source cycles of each period
  assign span    = {1'b0, dv2} + 1'b1;
  assign half    = span[DIV_W:1];
  assign cnt_nxt = (cnt >= dv2) ? '0 : cnt + 1'b1;

  always_ff @(posedge src_clk) begin
    rs_q <= {rs_q[0], rst};
    if (rs_q[1]) begin
      dv1 <= '0;
      dv2 <= '0;
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      dv1 <= div_val;
      dv2 <= dv1;
      cnt <= cnt_nxt;
      q   <= (cnt_nxt < half);
    end
  end

  assign drst = rs_q[1];
  assign dclk = (dv2 == '0) ? src_clk : q;
endmodule

// File: rtl/divmux_switch.sv
module divmux_switch import divmux_pkg::*; (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] dclk,
  input  logic [NSRC-1:0] drst,
  input  sel_t            sel_q,
  input  sel_t            sel_d,
  output logic            clk_out,
  output logic [NSRC-1:0] running
);
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] fb1, fb2;

  for (genvar i = 0; i < NSRC; i++) begin : g_leg
    logic want, blocked, arm_q, en_q;
    assign want    = (sel_q == sel_t'(i));
    assign blocked = |(en & ~(NSRC'(1) << i));

    always_ff @(posedge dclk[i]) begin
      if (drst[i]) arm_q <= 1'b0;
      else         arm_q <= want & ~blocked;
    end

    // enable changes only while this leg's clock is low
    always_ff @(negedge dclk[i]) begin
      if (drst[i]) en_q <= 1'b0;
      else         en_q <= arm_q;
    end

    assign en[i] = en_q;
  end

  assign clk_out = |(dclk & en);

  always_ff @(posedge clk) begin
    if (rst) begin
      fb1     <= '0;
      fb2     <= '0;
      running <= '0;
    end else begin
      fb1 <= en;
      fb2 <= fb1;
      for (int i = 0; i < NSRC; i++)
        running[i] <= fb2[i] && (sel_d == sel_t'(i));
    end
  end
endmodule

// File: rtl/divmux_channel.sv
module divmux_channel import divmux_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DIV_W = 5,
  parameter int CHAN_IDX = 3,
  parameter int SEL_START = 28,
  parameter logic [ADDR_W-1:0] SEL_ADDR_A = 12'h040,
  parameter logic [ADDR_W-1:0] SEL_ADDR_B = 12'h044,
  parameter logic [ADDR_W-1:0] DIV_BASE0 = 12'h100,
  parameter logic [ADDR_W-1:0] DIV_BASE1 = 12'h180,
  parameter logic [ADDR_W-1:0] DIV_BASE2 = 12'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              gate_off,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NSRC-1:0]   src_clk,
  output logic              clk_out,
  output logic [NSRC-1:0]   running
);
  sel_t sel_q, sel_d;
  logic [NSRC-1:0][DIV_W-1:0] div_q;
  logic [NSRC-1:0] dclk, drst;

  divmux_regs #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CHAN_IDX(CHAN_IDX), .SEL_START(SEL_START),
    .SEL_ADDR_A(SEL_ADDR_A), .SEL_ADDR_B(SEL_ADDR_B),
    .DIV_BASE0(DIV_BASE0), .DIV_BASE1(DIV_BASE1), .DIV_BASE2(DIV_BASE2)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate_off(gate_off), .rd_addr(rd_addr), .rd_data(rd_data),
    .sel_q(sel_q), .sel_d(sel_d), .div_q(div_q)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_div
    divmux_divider #(.DIV_W(DIV_W)) u_div (
      .src_clk(src_clk[s]), .rst(rst), .div_val(div_q[s]),
      .dclk(dclk[s]), .drst(drst[s])
    );
  end

  divmux_switch u_sw (
    .clk(clk), .rst(rst), .dclk(dclk), .drst(drst),
    .sel_q(sel_q), .sel_d(sel_d), .clk_out(clk_out), .running(running)
  );
endmodule

// File: rtl/divmux_channel_chk.sv
module divmux_channel_chk import divmux_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DIV_W = 5,
  parameter int CHAN_IDX = 3,
  parameter int SEL_START = 28,
  parameter logic [ADDR_W-1:0] SEL_ADDR_A = 12'h040,
  parameter logic [ADDR_W-1:0] SEL_ADDR_B = 12'h044,
  parameter logic [ADDR_W-1:0] DIV_BASE0 = 12'h100,
  parameter logic [ADDR_W-1:0] DIV_BASE1 = 12'h180,
  parameter logic [ADDR_W-1:0] DIV_BASE2 = 12'h200
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [31:0]                wr_data,
  input logic                       gate_off,
  input logic [NSRC-1:0]            running,
  input sel_t                       sel_q,
  input logic [NSRC-1:0][DIV_W-1:0] div_q
);
  localparam int SEL_POS = SEL_START + 2 * CHAN_IDX;
  localparam bit SEL_HI = (SEL_POS >= 32);
  localparam int SEL_SHIFT = SEL_HI ? SEL_POS - 32 : SEL_POS;
  localparam logic [ADDR_W-1:0] SEL_ADDR = SEL_HI ? SEL_ADDR_B : SEL_ADDR_A;

  sel_t code;
  logic sel_wr;
  logic unused_wr;
  assign code = wr_data[SEL_SHIFT +: SEL_W];
  assign sel_wr = wr_en && (wr_addr == SEL_ADDR) && !gate_off;
  assign unused_wr = ^wr_data;

  // R1
  reset_off_chk: assert property (@(posedge clk) rst |=> (sel_q == SEL_OFF) && (running == '0));

  // R8
  running_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(running));

  // R8
  running_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (running != '0) |-> (sel_q != SEL_OFF) && running[sel_q[SEL_W-1:0] % NSRC]);

  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    gate_off |=> (sel_q == SEL_OFF) && (running == '0));

  // R3
  reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && (code == SEL_OFF)) |=> $stable(sel_q));

  // R3
  accept_code_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && (code != SEL_OFF)) |=> (sel_q == $past(code)));

  for (genvar s = 0; s < NSRC; s++) begin : g_div_chk
    localparam logic [ADDR_W-1:0] BASE = (s == 0) ? DIV_BASE0 : (s == 1) ? DIV_BASE1 : DIV_BASE2;
    localparam logic [ADDR_W-1:0] DADDR = BASE + ADDR_W'(4 * CHAN_IDX);
    // R5
    div_store_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_addr == DADDR)) |=> (div_q[s] == $past(wr_data[DIV_W-1:0])));
  end
endmodule

bind divmux_channel divmux_channel_chk #(
  .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CHAN_IDX(CHAN_IDX), .SEL_START(SEL_START),
  .SEL_ADDR_A(SEL_ADDR_A), .SEL_ADDR_B(SEL_ADDR_B),
  .DIV_BASE0(DIV_BASE0), .DIV_BASE1(DIV_BASE1), .DIV_BASE2(DIV_BASE2)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .gate_off(gate_off), .running(running), .sel_q(sel_q), .div_q(div_q)
);

// File: tb/divmux_channel_tb.sv
module divmux_channel_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [11:0] A_SEL_LO = 12'h040;
  localparam logic [11:0] A_SEL_HI = 12'h044;
  localparam int          FLD_BIT  = 28 + 2 * 3 - 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        gate_off = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  src_clk = 3'b000;
  logic        clk_out;
  logic [2:0]  running;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  real min_w = 1.0e9;
  real last_r = -1.0;
  real last_f = -1.0;

  always #4.0 clk = ~clk;
  always #5.0 src_clk[0] = ~src_clk[0];
  always #7.0 src_clk[1] = ~src_clk[1];
  always #11.0 src_clk[2] = ~src_clk[2];

  divmux_channel u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate_off(gate_off), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_clk(src_clk), .clk_out(clk_out), .running(running)
  );

  // narrowest pulse monitor for R7
  always @(posedge clk_out) begin
    if (last_f >= 0.0 && ($realtime - last_f) < min_w) min_w = $realtime - last_f;
    last_r = $realtime;
  end
  always @(negedge clk_out) begin
    if (last_r >= 0.0 && ($realtime - last_r) < min_w) min_w = $realtime - last_r;
    last_f = $realtime;
  end

  function automatic real src_per(input int s);
    return (s == 0) ? 10.0 : (s == 1) ? 14.0 : 22.0;
  endfunction

  function automatic logic [11:0] div_addr(input int s);
    return ((s == 0) ? 12'h100 : (s == 1) ? 12'h180 : 12'h200) + 12'd12;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse_off();
    @(negedge clk);
    gate_off = 1'b1;
    @(negedge clk);
    gate_off = 1'b0;
  endtask

  task automatic wait_run(input int s, input string req);
    bit seen = 1'b0;
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (running == 3'(1 << s)) seen = 1'b1;
    end
    chk(seen, req, running, 1 << s);
  endtask

  task automatic measure(input int s, input int n, input string req);
    real t1, t2;
    @(posedge clk_out);
    @(posedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    chk(((t2 - t1) - src_per(s) * (n + 1)) < 0.01 && ((t2 - t1) - src_per(s) * (n + 1)) > -0.01,
        req, longint'((t2 - t1) * 1000.0), longint'(src_per(s) * (n + 1) * 1000.0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int nlist [5] = '{0, 1, 2, 5, 31};
    int edges;

    repeat (10) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(A_SEL_HI, d); chk(d == (32'd3 << FLD_BIT), "R1 select field after reset", d, 32'd3 << FLD_BIT);
    for (int s = 0; s < 3; s++) begin
      rd(div_addr(s), d); chk(d == 0, "R1 divider after reset", d, 0);
    end
    edges = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (clk_out !== 1'b0 || running != 0) edges++;
    end
    chk(edges == 0, "R1 clk_out low and running clear", edges, 0);

    // R2 field placement in the second select word
    wr(A_SEL_LO, 32'hFFFF_FFFF);
    rd(A_SEL_LO, d); chk(d == 0, "R2 first select word reads zero", d, 0);
    rd(A_SEL_HI, d); chk(d == (32'd3 << FLD_BIT), "R2 first word write ignored", d, 32'd3 << FLD_BIT);
    repeat (20) @(negedge clk);
    chk(running == 0, "R2 no start from first-word write", running, 0);
    wr(A_SEL_HI, 32'hFFFF_FFF7);
    rd(A_SEL_HI, d); chk(d == (32'd1 << FLD_BIT), "R2 only field bits read back", d, 32'd1 << FLD_BIT);
    wait_run(1, "R8 running after select 1");
    pulse_off();
    repeat (400) @(negedge clk);

    // R5 R6 R8 sweep over sources and divider values
    for (int s = 0; s < 3; s++) begin
      for (int j = 0; j < 5; j++) begin
        wr(div_addr(s), 32'hFFFF_FFE0 | 32'(nlist[j]));
        rd(div_addr(s), d); chk(d == 32'(nlist[j]), "R5 divider readback", d, nlist[j]);
        wr(A_SEL_HI, 32'(s) << FLD_BIT);
        wait_run(s, "R8 running follows select");
        measure(s, nlist[j], "R6 output period");
        pulse_off();
        chk(running == 0, "R4 running clear after gate-off", running, 0);
        repeat (400) @(negedge clk);
      end
    end

    // R3 reserved code refused while running
    wr(div_addr(0), 0); wr(div_addr(1), 1); wr(div_addr(2), 2);
    wr(A_SEL_HI, 32'd2 << FLD_BIT);
    wait_run(2, "R8 running on source 2");
    wr(A_SEL_HI, 32'd3 << FLD_BIT);
    rd(A_SEL_HI, d); chk(d == (32'd2 << FLD_BIT), "R3 reserved code ignored", d, 32'd2 << FLD_BIT);
    chk(running == 3'b100, "R3 running kept after reserved write", running, 3'b100);
    measure(2, 2, "R3 output unchanged after reserved write");

    // R6 R7 R8 live switches between sources
    wr(A_SEL_HI, 32'd0 << FLD_BIT);
    wait_run(0, "R8 live switch to 0");
    measure(0, 0, "R6 pass-through after live switch");
    wr(A_SEL_HI, 32'd1 << FLD_BIT);
    wait_run(1, "R8 live switch to 1");
    measure(1, 1, "R6 divide by two after live switch");
    wr(A_SEL_HI, 32'd2 << FLD_BIT);
    wait_run(2, "R8 live switch to 2");
    wr(A_SEL_HI, 32'd0 << FLD_BIT);
    wait_run(0, "R8 live switch back to 0");

    // R4 gate-off wins over a same-cycle select write
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_SEL_HI; wr_data = 32'd1 << FLD_BIT; gate_off = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; gate_off = 1'b0;
    chk(running == 0, "R4 running dropped at once", running, 0);
    rd(A_SEL_HI, d); chk(d == (32'd3 << FLD_BIT), "R4 gate-off priority", d, 32'd3 << FLD_BIT);

    // R9 output held low once released
    repeat (400) @(negedge clk);
    edges = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (clk_out !== 1'b0) edges++;
    end
    chk(edges == 0, "R9 clk_out held low when off", edges, 0);

    // R7 narrowest pulse over the whole run (4.9 ns = fastest half period less margin)
    chk(min_w > 4.9, "R7 no runt pulse", longint'(min_w * 1000.0), 4900);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule